// File: doc/BRIEF.md
# String Compare and Scan Unit

This unit carries out a single iteration of the two comparing string operations of an integer core. These are the memory-to-memory compare and the accumulator scan. A start pulse hands it the operation, the element size, the address mode, the direction flag, two segment bases, the source and destination index registers and the accumulator. The unit then fetches one or two elements through a simple request/acknowledge read port. It subtracts them at the element width and keeps the resulting arithmetic flags. It also produces the stepped index values and reports the cycle cost of the instruction.

Compare fetches the source element first and the destination element second, and computes source minus destination. Scan fetches only the destination element and computes accumulator minus that element. Its source index comes back unchanged. The difference itself is never written anywhere. If a read reports an abort, the flags and both indices keep their previous values. The unit does not handle repeat prefixes or segment limit checks.

Top module: `ssu_top`

## Requirements
- R1: Compare (`op_scan`=0) reads first at `src_base` plus the source index, then at `dst_base` plus the destination index, and computes flags for source element minus destination element.
- R2: Scan (`op_scan`=1) issues exactly one read, at `dst_base` plus the destination index. It computes flags for accumulator minus memory element and returns the source index unchanged.
- R3: The carry (borrow), zero, sign and overflow flags follow an unsigned/signed subtraction at the element width. `flags_out` packs them as bit 5 overflow, bit 4 sign, bit 3 zero and bit 0 carry.
- R4: Bit 2 of `flags_out` is the borrow out of bit 3 (auxiliary carry). Bit 1 is set when the low result byte has an even number of ones.
- R5: A read answered with `mem_abort` ends the operation with `done` and `aborted` high. `flags_out` keeps its previous value, both index outputs equal the indices given at start, and no further read is issued.
- R6: `elem_size` 0, 1 and 2 select byte, word and doubleword (3 acts as doubleword). The indices step by 1, 2 or 4, upward when `dir_down`=0 and downward when it is 1.
- R7: With `addr32`=0 the effective addresses use only the low 16 bits of each index. Stepping wraps within those 16 bits and the upper 16 bits come back unchanged.
- R8: `cost_out` is 7 for scan. For compare it is 8 when `later_gen`=1 and 10 otherwise.
- R9: A start while `busy` is high is ignored and changes neither the running operation nor its captured operands. After `done` the unit is idle with no read pending.
- R10: After reset `done`, `busy`, `mem_req`, `flags_out`, both index outputs and `cost_out` are all zero.
- R11: Accumulator and memory data bits above the element width do not affect the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one iteration (accepted only when idle) |
| op_scan | input | 1 | 0 = compare, 1 = scan |
| elem_size | input | 2 | Element size: 0 byte, 1 word, 2/3 doubleword |
| addr32 | input | 1 | 1 = 32-bit indices, 0 = 16-bit indices |
| dir_down | input | 1 | Direction flag, 1 = decrement |
| later_gen | input | 1 | Selects the later core generation's compare cost |
| src_base | input | 32 | Source segment base |
| dst_base | input | 32 | Destination segment base |
| src_idx | input | 32 | Source index register |
| dst_idx | input | 32 | Destination index register |
| acc | input | 32 | Accumulator |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_size | output | 2 | Read element size |
| mem_ack | input | 1 | Read acknowledge |
| mem_abort | input | 1 | Read faulted, valid with `mem_ack` |
| mem_data | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Completion was caused by an abort |
| flags_out | output | 6 | Arithmetic flags {OF,SF,ZF,AF,PF,CF} |
| src_idx_out | output | 32 | Source index after the iteration |
| dst_idx_out | output | 32 | Destination index after the iteration |
| cost_out | output | 4 | Cycle cost of the iteration |

## Verification
Two events can share one cycle in this unit. The final read can be acknowledged in the very cycle it also reports an abort, so completion and fault fall on the same edge. A fresh start can also arrive while a read is still waiting for its acknowledge. The bench aborts compares on the first read and on the second, and aborts scans on their only read. It then judges that the flags equal those of the last successful operation and that the indices come back untouched. During random acknowledge delays it drives start with a different operation and different indices. It then expects the original operation's addresses, flags and indices, and an idle port one cycle after completion.

// File: rtl/ssu_pkg.sv
`timescale 1ns/1ps
package ssu_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_WIDE  = 2'd3
  } esize_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_SRC  = 2'd1,
    ST_RD_DST  = 2'd2
  } sstate_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } sflags_t;

  function automatic word_t size_mask(input logic [1:0] sz);
    word_t m;
    case (sz)
      SZ_BYTE: m = word_t'(8'hFF);
      SZ_WORD: m = word_t'(16'hFFFF);
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic size_msb(input word_t v, input logic [1:0] sz);
    logic b;
    case (sz)
      SZ_BYTE: b = v[7];
      SZ_WORD: b = v[15];
      default: b = v[WORD_W-1];
    endcase
    return b;
  endfunction

  function automatic word_t step_amount(input logic [1:0] sz);
    word_t n;
    case (sz)
      SZ_BYTE: n = word_t'(1);
      SZ_WORD: n = word_t'(2);
      default: n = word_t'(4);
    endcase
    return n;
  endfunction

  function automatic word_t next_index(input word_t idx, input logic [1:0] sz,
                                       input logic down, input logic wide);
    word_t n;
    word_t s;
    n = step_amount(sz);
    s = down ? (idx - n) : (idx + n);
    return wide ? s : {idx[WORD_W-1:HALF_W], s[HALF_W-1:0]};
  endfunction

  function automatic word_t eff_addr(input word_t base, input word_t idx, input logic wide);
    word_t off;
    off = wide ? idx : {{HALF_W{1'b0}}, idx[HALF_W-1:0]};
    return base + off;
  endfunction

  function automatic sflags_t sub_flags(input word_t a_in, input word_t b_in,
                                        input logic [1:0] sz);
    word_t   m;
    word_t   a;
    word_t   b;
    word_t   r;
    sflags_t f;
    m = size_mask(sz);
    a = a_in & m;
    b = b_in & m;
    r = (a - b) & m;
    f.cry = (a < b);
    f.zro = (r == '0);
    f.sgn = size_msb(r, sz);
    f.ovf = (size_msb(a, sz) ^ size_msb(b, sz)) & (size_msb(a, sz) ^ size_msb(r, sz));
    f.aux = a[4] ^ b[4] ^ r[4];
    f.par = ~^r[7:0];
    return f;
  endfunction
endpackage

// File: rtl/ssu_flag_unit.sv
`timescale 1ns/1ps
module ssu_flag_unit
  import ssu_pkg::*;
(
  input  word_t      minuend,
  input  word_t      subtrahend,
  input  logic [1:0] elem_size,
  output sflags_t    flags
);
  always_comb begin
    flags = sub_flags(minuend, subtrahend, elem_size);
  end
endmodule

// File: rtl/ssu_idx_step.sv
`timescale 1ns/1ps
module ssu_idx_step
  import ssu_pkg::*;
(
  input  word_t      idx_cur,
  input  logic [1:0] elem_size,
  input  logic       dir_down,
  input  logic       wide,
  input  logic       hold,
  output word_t      idx_nxt
);
  always_comb begin
    if (hold) idx_nxt = idx_cur;
    else      idx_nxt = next_index(idx_cur, elem_size, dir_down, wide);
  end
endmodule

// File: rtl/ssu_seq.sv
`timescale 1ns/1ps
module ssu_seq
  import ssu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    op_scan,
  input  logic    mem_ack,
  input  logic    mem_abort,
  input  word_t   mem_data,
  output sstate_e state,
  output logic    accept,
  output logic    fin,
  output logic    fin_abort,
  output word_t   first_q
);
  sstate_e state_nx;

  assign accept    = start && (state == ST_IDLE);
  assign fin       = mem_ack && ((state == ST_RD_DST) ||
                                 ((state == ST_RD_SRC) && mem_abort));
  assign fin_abort = fin && mem_abort;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (accept) state_nx = op_scan ? ST_RD_DST : ST_RD_SRC;
      ST_RD_SRC: if (mem_ack) state_nx = mem_abort ? ST_IDLE : ST_RD_DST;
      ST_RD_DST: if (mem_ack) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      first_q <= '0;
    end else begin
      state <= state_nx;
      if ((state == ST_RD_SRC) && mem_ack && !mem_abort) first_q <= mem_data;
    end
  end
endmodule

// File: rtl/ssu_top.sv
`timescale 1ns/1ps
module ssu_top
  import ssu_pkg::*;
#(
  parameter int COST_W       = 4,
  parameter int CMP_COST_NEW = 8,
  parameter int CMP_COST_OLD = 10,
  parameter int SCAN_COST    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_scan,
  input  logic [1:0]        elem_size,
  input  logic              addr32,
  input  logic              dir_down,
  input  logic              later_gen,
  input  logic [31:0]       src_base,
  input  logic [31:0]       dst_base,
  input  logic [31:0]       src_idx,
  input  logic [31:0]       dst_idx,
  input  logic [31:0]       acc,
  output logic              busy,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  input  logic              mem_ack,
  input  logic              mem_abort,
  input  logic [31:0]       mem_data,
  output logic              done,
  output logic              aborted,
  output logic [5:0]        flags_out,
  output logic [31:0]       src_idx_out,
  output logic [31:0]       dst_idx_out,
  output logic [COST_W-1:0] cost_out
);
  localparam int NUM_IDX = 2;
  localparam logic [COST_W-1:0] C_NEW  = COST_W'(CMP_COST_NEW);
  localparam logic [COST_W-1:0] C_OLD  = COST_W'(CMP_COST_OLD);
  localparam logic [COST_W-1:0] C_SCAN = COST_W'(SCAN_COST);

  // operands captured when an operation is accepted
  logic       cap_scan;
  logic [1:0] cap_size;
  logic       cap_a32;
  logic       cap_down;
  logic       cap_later;
  word_t      cap_sbase;
  word_t      cap_dbase;
  word_t      cap_src;
  word_t      cap_dst;
  word_t      cap_acc;

  // internal events brought out for the checker
  sstate_e    state;
  logic       accept;
  logic       fin;
  logic       fin_abort;
  word_t      first_q;
  word_t      alu_a;
  sflags_t    alu_flags;
  word_t      idx_cur [NUM_IDX];
  word_t      idx_nxt [NUM_IDX];
  logic       idx_hold [NUM_IDX];
  logic [COST_W-1:0] cost_nx;
  sflags_t    flags_q;

  ssu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_scan   (op_scan),
    .mem_ack   (mem_ack),
    .mem_abort (mem_abort),
    .mem_data  (mem_data),
    .state     (state),
    .accept    (accept),
    .fin       (fin),
    .fin_abort (fin_abort),
    .first_q   (first_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_scan  <= 1'b0;
      cap_size  <= SZ_BYTE;
      cap_a32   <= 1'b0;
      cap_down  <= 1'b0;
      cap_later <= 1'b0;
      cap_sbase <= '0;
      cap_dbase <= '0;
      cap_src   <= '0;
      cap_dst   <= '0;
      cap_acc   <= '0;
    end else if (accept) begin
      cap_scan  <= op_scan;
      cap_size  <= elem_size;
      cap_a32   <= addr32;
      cap_down  <= dir_down;
      cap_later <= later_gen;
      cap_sbase <= src_base;
      cap_dbase <= dst_base;
      cap_src   <= src_idx;
      cap_dst   <= dst_idx;
      cap_acc   <= acc;
    end
  end

  // read port
  assign busy     = (state != ST_IDLE);
  assign mem_req  = busy;
  assign mem_size = cap_size;
  always_comb begin
    if (state == ST_RD_SRC) mem_addr = eff_addr(cap_sbase, cap_src, cap_a32);
    else                    mem_addr = eff_addr(cap_dbase, cap_dst, cap_a32);
  end

  // subtraction: compare uses the fetched source, scan the accumulator
  assign alu_a = cap_scan ? cap_acc : first_q;

  ssu_flag_unit u_flags (
    .minuend    (alu_a),
    .subtrahend (mem_data),
    .elem_size  (cap_size),
    .flags      (alu_flags)
  );

  assign idx_cur[0]  = cap_src;
  assign idx_cur[1]  = cap_dst;
  assign idx_hold[0] = cap_scan;
  assign idx_hold[1] = 1'b0;

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    ssu_idx_step u_step (
      .idx_cur   (idx_cur[g]),
      .elem_size (cap_size),
      .dir_down  (cap_down),
      .wide      (cap_a32),
      .hold      (idx_hold[g]),
      .idx_nxt   (idx_nxt[g])
    );
  end

  always_comb begin
    if (cap_scan)       cost_nx = C_SCAN;
    else if (cap_later) cost_nx = C_NEW;
    else                cost_nx = C_OLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      aborted     <= 1'b0;
      flags_q     <= '0;
      src_idx_out <= '0;
      dst_idx_out <= '0;
      cost_out    <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        aborted  <= fin_abort;
        cost_out <= cost_nx;
        if (fin_abort) begin
          src_idx_out <= cap_src;
          dst_idx_out <= cap_dst;
        end else begin
          flags_q     <= alu_flags;
          src_idx_out <= idx_nxt[0];
          dst_idx_out <= idx_nxt[1];
        end
      end
    end
  end

  assign flags_out = flags_q;
endmodule

// File: rtl/ssu_chk.sv
`timescale 1ns/1ps
module ssu_chk #(
  parameter int COST_W       = 4,
  parameter int CMP_COST_NEW = 8,
  parameter int CMP_COST_OLD = 10,
  parameter int SCAN_COST    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              aborted,
  input logic              fin,
  input logic [5:0]        flags_out,
  input logic [31:0]       src_idx_out,
  input logic [31:0]       dst_idx_out,
  input logic [COST_W-1:0] cost_out,
  input logic              cap_scan,
  input logic              cap_a32,
  input logic [31:0]       cap_src,
  input logic [31:0]       cap_dst
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && aborted) |-> $stable(flags_out));

  p_abort_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && aborted) |-> (src_idx_out == cap_src) && (dst_idx_out == cap_dst));

  p_scan_src_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_scan) |-> (src_idx_out == cap_src));

  p_lockstep_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !aborted && !cap_scan) |->
      ((src_idx_out[15:0] - cap_src[15:0]) == (dst_idx_out[15:0] - cap_dst[15:0])));

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_a32) |->
      (src_idx_out[31:16] == cap_src[31:16]) && (dst_idx_out[31:16] == cap_dst[31:16]));

  p_cost_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_scan) |-> (cost_out == COST_W'(SCAN_COST)));

  p_cost_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_scan) |->
      ((cost_out == COST_W'(CMP_COST_NEW)) || (cost_out == COST_W'(CMP_COST_OLD))));

  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);

  p_capture_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(cap_src) && $stable(cap_dst) && $stable(cap_scan));
endmodule

bind ssu_top ssu_chk #(
  .COST_W       (COST_W),
  .CMP_COST_NEW (CMP_COST_NEW),
  .CMP_COST_OLD (CMP_COST_OLD),
  .SCAN_COST    (SCAN_COST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .aborted     (aborted),
  .fin         (fin),
  .flags_out   (flags_out),
  .src_idx_out (src_idx_out),
  .dst_idx_out (dst_idx_out),
  .cost_out    (cost_out),
  .cap_scan    (cap_scan),
  .cap_a32     (cap_a32),
  .cap_src     (cap_src),
  .cap_dst     (cap_dst)
);

// File: tb/sim_ssu_top.sv
`timescale 1ns/1ps
module sim_ssu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_scan = 1'b0;
  logic [1:0]  elem_size = 2'd0;
  logic        addr32 = 1'b0;
  logic        dir_down = 1'b0;
  logic        later_gen = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, src_idx = '0, dst_idx = '0, acc = '0;
  logic        busy, mem_req;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0, mem_abort = 1'b0;
  logic [31:0] mem_data = '0;
  logic        done, aborted;
  logic [5:0]  flags_out;
  logic [31:0] src_idx_out, dst_idx_out;
  logic [3:0]  cost_out;

  int checks = 0;
  int errors = 0;
  logic [5:0] last_flags = '0;

  always #2 clk = ~clk;

  ssu_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_scan(op_scan), .elem_size(elem_size),
    .addr32(addr32), .dir_down(dir_down), .later_gen(later_gen),
    .src_base(src_base), .dst_base(dst_base), .src_idx(src_idx), .dst_idx(dst_idx),
    .acc(acc), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_ack(mem_ack), .mem_abort(mem_abort), .mem_data(mem_data), .done(done),
    .aborted(aborted), .flags_out(flags_out), .src_idx_out(src_idx_out),
    .dst_idx_out(dst_idx_out), .cost_out(cost_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] e_flags(input logic [31:0] a_in, input logic [31:0] b_in,
                                         input logic [1:0] sz);
    int     w;
    longint m, a, b, r, sa, sb, sd, lim;
    logic   cf, zf, sf, of, af, pf;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m   = (longint'(1) << w) - 1;
    a   = longint'(a_in) & m;
    b   = longint'(b_in) & m;
    r   = (a - b) & m;
    lim = longint'(1) << (w - 1);
    sa  = (a >= lim) ? a - (lim * 2) : a;
    sb  = (b >= lim) ? b - (lim * 2) : b;
    sd  = sa - sb;
    cf  = (a < b);
    zf  = (r == 0);
    sf  = ((r >> (w - 1)) & 1) != 0;
    of  = (sd >= lim) || (sd < -lim);
    af  = ((a & 15) < (b & 15));
    pf  = ($countones(r & 255) % 2) == 0;
    return {of, sf, zf, af, pf, cf};
  endfunction

  function automatic logic [31:0] e_step(input logic [31:0] idx, input logic [1:0] sz,
                                         input bit down, input bit a32);
    logic [31:0] n, s;
    logic [15:0] l;
    n = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    s = down ? idx - n : idx + n;
    l = down ? idx[15:0] - n[15:0] : idx[15:0] + n[15:0];
    return a32 ? s : {idx[31:16], l};
  endfunction

  function automatic logic [31:0] e_addr(input logic [31:0] base, input logic [31:0] idx,
                                         input bit a32);
    return a32 ? base + idx : base + {16'h0, idx[15:0]};
  endfunction

  task automatic serve_read(input logic [31:0] exp_addr, input logic [31:0] data,
                            input bit ab, input string req, input bit poke);
    int waits;
    waits = $urandom_range(0, 2);
    chk(mem_req === 1'b1, req, "read request", longint'(mem_req), 1);
    chk(mem_addr === exp_addr, req, "read address", longint'(mem_addr), longint'(exp_addr));
    for (int k = 0; k < waits; k++) begin
      if (poke) begin
        start   = 1'b1;
        op_scan = ~op_scan;
        src_idx = $urandom;
        dst_idx = $urandom;
        acc     = $urandom;
      end
      @(negedge clk);
      start = 1'b0;
    end
    mem_ack   = 1'b1;
    mem_data  = data;
    mem_abort = ab;
    @(negedge clk);
    mem_ack   = 1'b0;
    mem_abort = 1'b0;
    mem_data  = $urandom;
  endtask

  task automatic run_op(input bit scan, input logic [1:0] sz, input bit a32, input bit down,
                        input bit later, input logic [31:0] sb, input logic [31:0] db,
                        input logic [31:0] si, input logic [31:0] di, input logic [31:0] ac,
                        input logic [31:0] ds, input logic [31:0] dd,
                        input bit ab_s, input bit ab_d, input bit poke);
    bit          ab;
    logic [31:0] a, b, exp_s, exp_d;
    logic [5:0]  ef;
    int          ecost;
    op_scan = scan; elem_size = sz; addr32 = a32; dir_down = down; later_gen = later;
    src_base = sb; dst_base = db; src_idx = si; dst_idx = di; acc = ac;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!scan) begin
      serve_read(e_addr(sb, si, a32), ds, ab_s, a32 ? "R1" : "R7", poke);
      if (!ab_s) serve_read(e_addr(db, di, a32), dd, ab_d, a32 ? "R1" : "R7", poke);
      ab = ab_s || ab_d;
      a  = ds;
    end else begin
      serve_read(e_addr(db, di, a32), dd, ab_d, "R2", poke);
      ab = ab_d;
      a  = ac;
    end
    b = dd;
    chk(done === 1'b1, "R1", "done after last read", longint'(done), 1);
    chk(aborted === ab, "R5", "aborted", longint'(aborted), longint'(ab));
    ecost = scan ? 7 : (later ? 8 : 10);
    chk(cost_out == 4'(ecost), "R8", "cost", longint'(cost_out), longint'(ecost));
    if (ab) begin
      chk(flags_out == last_flags, "R5", "flags kept on abort", longint'(flags_out), longint'(last_flags));
      chk(src_idx_out == si, "R5", "src index kept", longint'(src_idx_out), longint'(si));
      chk(dst_idx_out == di, "R5", "dst index kept", longint'(dst_idx_out), longint'(di));
    end else begin
      ef = e_flags(a, b, sz);
      chk({flags_out[5:3], flags_out[0]} == {ef[5:3], ef[0]}, "R3", "OF/SF/ZF/CF",
          longint'(flags_out), longint'(ef));
      chk(flags_out[2:1] == ef[2:1], "R4", "AF/PF", longint'(flags_out), longint'(ef));
      last_flags = ef;
      exp_s = scan ? si : e_step(si, sz, down, a32);
      exp_d = e_step(di, sz, down, a32);
      chk(src_idx_out == exp_s, scan ? "R2" : (a32 ? "R6" : "R7"), "src index",
          longint'(src_idx_out), longint'(exp_s));
      chk(dst_idx_out == exp_d, a32 ? "R6" : "R7", "dst index",
          longint'(dst_idx_out), longint'(exp_d));
    end
    @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0 && busy === 1'b0, "R9", "idle after done",
        longint'({done, mem_req, busy}), 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R10", "reset controls",
        longint'({done, busy, mem_req}), 0);
    chk(flags_out === 6'd0 && cost_out === 4'd0, "R10", "reset flags/cost",
        longint'({flags_out, cost_out}), 0);
    chk(src_idx_out === 32'd0 && dst_idx_out === 32'd0, "R10", "reset indices",
        longint'(src_idx_out ^ dst_idx_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_op(0, 2'd0, 1, 0, 0, 32'h1000, 32'h2000, 32'h100, 32'h200, 0, 32'h5A, 32'h5A, 0, 0, 0);     // R1 equal
    run_op(0, 2'd0, 0, 1, 1, 32'h10, 32'h20, 32'hABCD0000, 32'h12340000, 0, 32'h00, 32'h01, 0, 0, 0); // R7 wrap down
    run_op(0, 2'd0, 1, 0, 0, 0, 0, 5, 9, 0, 32'h80, 32'h01, 0, 0, 0);                                 // R3 overflow
    run_op(0, 2'd2, 1, 0, 1, 0, 32'h40, 32'hFFFFFFFE, 32'hFFFFFFFC, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0, 0); // R6 wrap
    run_op(0, 2'd1, 0, 0, 1, 32'h300, 32'h500, 32'h0001FFFE, 32'h7, 0, 32'h0010, 32'h0008, 0, 0, 0);   // R7 wrap up
    run_op(1, 2'd1, 1, 1, 0, 0, 32'h80, 32'h55, 32'h60, 32'h12348000, 32'hFFFF0001, 32'hFFFF0001, 0, 0, 0); // R2 R11
    run_op(1, 2'd3, 1, 0, 1, 0, 0, 32'h77, 32'h88, 32'h1, 32'h0, 32'h2, 0, 1, 0);                    // R5 scan abort
    run_op(0, 2'd0, 1, 0, 0, 0, 0, 32'h10, 32'h20, 0, 32'h3, 32'h3, 1, 0, 0);                         // R5 first read
    run_op(0, 2'd1, 1, 1, 1, 0, 0, 32'h10, 32'h20, 0, 32'h3, 32'h4, 0, 1, 0);                         // R5 second read
    run_op(1, 2'd0, 1, 0, 0, 0, 32'h4, 32'h9, 32'h9, 32'hFFFFFF42, 32'hAAAAAA42, 32'hAAAAAA42, 0, 0, 0); // R11 equal low byte
    run_op(0, 2'd2, 1, 0, 0, 32'h100, 32'h200, 32'h30, 32'h40, 0, 32'h1, 32'h2, 0, 0, 1);             // R9 start while busy
    // random mix
    for (int i = 0; i < 400; i++) begin
      run_op($urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom, $urandom, $urandom,
             $urandom, $urandom, $urandom, $urandom, ($urandom_range(0, 9) == 0),
             ($urandom_range(0, 9) == 0), $urandom_range(0, 1));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule